// File: doc/BRIEF.md
# PIO Sector-Transfer Interrupt Pacer

This block paces programmed-I/O read transfers for a disk drive. A read command fixes a byte length, the starting logical block address and the number of sectors that make up one interrupt period. Each read of the data port then moves a byte index forward by the access width. When a read starts at a nonzero sector boundary, the block asks the sector source for the next sector and increments the block address. It raises an interrupt at the end of each interrupt period and again on the last byte. At each interrupt it decides whether the host should still see a data request.

The block also decodes a small set of housekeeping commands that touch only the status and error bytes. These are drive identify, initialize drive parameters and recalibrate. It decodes the set-multiple command as well, which latches the block size used by multiple-sector reads. The sector storage itself lives outside the block. The block only drives the fetch request and the address.

Status byte layout: bit 7 busy, bit 6 ready, bit 4 seek complete, bit 3 data request, bit 0 error. The remaining bits are always 0.

All outputs are registered. A strobe sampled on one rising edge shows its effect on the outputs right after that edge. If a command and a read arrive in the same cycle, the command takes priority and the read is dropped.

Top module: `pio_irq_pacer`

## Requirements
- R1: After reset the outputs are: status 0x50, error byte 0x00, `irq` low, `nextSecReq` low and `lba` 0. The transfer length is 0, so the first data read after reset is an overrun.
- R2: Opcodes 0x20, 0x21, 0x24, 0xC8 and 0xC9 start a transfer paced one sector per interrupt. The length is `cmdCount`×512 bytes, with a count of 0 meaning 256 sectors. The index restarts at 0 and `lba` loads from `cmdLba`. The error byte becomes 0x00 and the status becomes 0x58. `nextSecReq` pulses for one cycle and no interrupt is raised.
- R3: Opcode 0xC4 starts a transfer in the same way as R2, but it is paced by the latched block size.
- R4: Opcode 0xC6 with `cmdCount` above MAX_MULT (default 16) aborts: status 0x41, error byte 0x04 and an interrupt. Otherwise it latches `cmdCount` as the block size, with 0 taken as 1. It then sets ready, clears the status error bit (keeping the other status bits), clears the error byte and raises an interrupt.
- R5: Opcode 0xEC on a disk (`isPacketDrive`=0) and opcode 0xA1 on a packet drive (`isPacketDrive`=1) set the error byte to 0x00 and the status to 0x58, and raise an interrupt. Either opcode on the other drive type aborts as in R4.
- R6: Opcodes 0x91 and 0x10 clear the status error bit, set ready and seek complete, clear the error byte and raise an interrupt.
- R7: A read taken while the index is below the length advances the index by `rdBytes` (1, 2 or 4, with one width used throughout a transfer). A read taken at or past the length is an overrun. An overrun sets status bit 0, sets the error byte to 0x04, raises no interrupt and leaves the index where it is.
- R8: A read that starts at a nonzero multiple of 512 pulses `nextSecReq` for one cycle and increments `lba` by 1.
- R9: An interrupt is raised when the index after a read reaches a multiple of 512×(sectors per interrupt), or equals the length. At such a point busy clears and ready sets. Data request stays set (status 0x58) if bytes remain, and clears (status 0x50) on the final byte.
- R10: Any other opcode changes nothing and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 8 | Command opcode |
| cmdCount | input | 8 | Sector count accompanying the command |
| cmdLba | input | LBA_W | Starting block address for read commands |
| isPacketDrive | input | 1 | 1 = packet drive, 0 = disk |
| rdValid | input | 1 | Data-port read strobe |
| rdBytes | input | 3 | Width of the read in bytes (1, 2 or 4) |
| status | output | 8 | Status byte |
| errReg | output | 8 | Error byte |
| irq | output | 1 | One-cycle interrupt pulse |
| nextSecReq | output | 1 | One-cycle request to load the sector at `lba` |
| lba | output | LBA_W | Address of the sector being supplied |

## Verification
The index and the sector-within-block counter are internal, so any error in them shows up at the ports as an interrupt that is early, late or missing. It can also show up as a `nextSecReq` pulse or `lba` step on the wrong read, or as status 0x58 where 0x50 is expected. Every such error appears one cycle after the read that exposes it. The bench therefore compares interrupt, fetch, address and status after every single read of whole transfers. These transfers run at several widths and block sizes, including the 256-sector case. A wrong length or a stuck index shows at the latest on the read just past the end: it either raises no overrun or raises one too early.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int SEC_SHIFT = 9;              // 512-byte sectors
  localparam int IDX_W     = SEC_SHIFT + 9;  // up to 256 sectors of bytes

  localparam logic [7:0] OP_RD_RETRY   = 8'h20;
  localparam logic [7:0] OP_RD_NORETRY = 8'h21;
  localparam logic [7:0] OP_RD_EXT     = 8'h24;
  localparam logic [7:0] OP_DMA_RETRY  = 8'hC8;
  localparam logic [7:0] OP_DMA        = 8'hC9;
  localparam logic [7:0] OP_RD_MULT    = 8'hC4;
  localparam logic [7:0] OP_SET_MULT   = 8'hC6;
  localparam logic [7:0] OP_ID_DISK    = 8'hEC;
  localparam logic [7:0] OP_ID_PKT     = 8'hA1;
  localparam logic [7:0] OP_INIT_PARAM = 8'h91;
  localparam logic [7:0] OP_RECAL      = 8'h10;

  localparam int BIT_BSY  = 7;
  localparam int BIT_RDY  = 6;
  localparam int BIT_SEEK = 4;
  localparam int BIT_DRQ  = 3;
  localparam int BIT_ERR  = 0;

  localparam logic [7:0] ST_IDLE  = 8'h50;
  localparam logic [7:0] ST_XFER  = 8'h58;
  localparam logic [7:0] ST_ABORT = 8'h41;
  localparam logic [7:0] ER_ABORT = 8'h04;

  typedef struct packed {
    logic setup;   // start a new transfer
    logic step;    // a data-port read this cycle
  } ctrl_strobe_t;

  typedef struct packed {
    logic accept;      // read taken inside the transfer
    logic overrun;     // read taken past the end
    logic irqPoint;    // read closes an interrupt period
    logic finalPoint;  // read delivers the last byte
  } dp_event_t;
endpackage

// File: rtl/pacer_datapath.sv
module pacer_datapath
  import pacer_pkg::*;
#(
  parameter int LBA_W = 28,
  parameter int CNT_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strobe,
  input  logic [7:0]         cmdCount,
  input  logic [LBA_W-1:0]   cmdLba,
  input  logic [2:0]         rdBytes,
  input  logic [CNT_W-1:0]   perIrq,
  output dp_event_t          evt,
  output logic [LBA_W-1:0]   lba,
  output logic               nextSecReq
);
  logic [IDX_W-1:0] xferIdx, xferLen, nextIdx, setupLen;
  logic [CNT_W-1:0] secInBlk;
  logic [8:0]       sectors;
  logic             isOver, fetch, secEnd, blkEnd, last;

  always_comb begin
    sectors  = {cmdCount == 8'd0, cmdCount};
    setupLen = {sectors, {SEC_SHIFT{1'b0}}};
    nextIdx  = xferIdx + IDX_W'(rdBytes);
    isOver   = xferIdx >= xferLen;
    fetch    = (xferIdx[SEC_SHIFT-1:0] == '0) && (xferIdx != '0);
    secEnd   = nextIdx[SEC_SHIFT-1:0] == '0;
    blkEnd   = secEnd && ((secInBlk + CNT_W'(1)) == perIrq);
    last     = nextIdx == xferLen;
    evt.accept     = strobe.step & ~isOver;
    evt.overrun    = strobe.step & isOver;
    evt.irqPoint   = evt.accept & (blkEnd | last);
    evt.finalPoint = evt.accept & last;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferIdx    <= '0;
      xferLen    <= '0;
      secInBlk   <= '0;
      lba        <= '0;
      nextSecReq <= 1'b0;
    end else begin
      nextSecReq <= 1'b0;
      if (strobe.setup) begin
        xferIdx    <= '0;
        xferLen    <= setupLen;
        secInBlk   <= '0;
        lba        <= cmdLba;
        nextSecReq <= 1'b1;
      end else if (evt.accept) begin
        xferIdx <= nextIdx;
        if (fetch) begin
          lba        <= lba + LBA_W'(1);
          nextSecReq <= 1'b1;
        end
        if (blkEnd)      secInBlk <= '0;
        else if (secEnd) secInBlk <= secInBlk + CNT_W'(1);
      end
    end
  end

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setup |=> (xferLen != '0)) else $error("length zero after setup"); // R2
  AST_SETUP_FRESH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setup |=> (xferIdx == '0) && nextSecReq) else $error("setup not fresh"); // R2
endmodule

// File: rtl/pacer_control.sv
module pacer_control
  import pacer_pkg::*;
#(
  parameter int MAX_MULT = 16,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [7:0]       cmdOp,
  input  logic [7:0]       cmdCount,
  input  logic             isPacketDrive,
  input  logic             rdValid,
  input  dp_event_t        evt,
  output ctrl_strobe_t     strobe,
  output logic [CNT_W-1:0] perIrq,
  output logic [7:0]       status,
  output logic [7:0]       errReg,
  output logic             irq
);
  localparam logic [7:0] MAX8 = 8'(MAX_MULT);

  logic [CNT_W-1:0] multCount;
  logic             isSingle, isMulti, tooBig;

  always_comb begin
    isSingle = (cmdOp == OP_RD_RETRY) || (cmdOp == OP_RD_NORETRY) ||
               (cmdOp == OP_RD_EXT) || (cmdOp == OP_DMA_RETRY) || (cmdOp == OP_DMA);
    isMulti  = cmdOp == OP_RD_MULT;
    tooBig   = cmdCount > MAX8;
    strobe.setup = cmdValid & (isSingle | isMulti);
    strobe.step  = rdValid & ~cmdValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status    <= ST_IDLE;
      errReg    <= 8'h00;
      multCount <= CNT_W'(1);
      perIrq    <= CNT_W'(1);
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (cmdValid) begin
        case (cmdOp)
          OP_RD_RETRY, OP_RD_NORETRY, OP_RD_EXT, OP_DMA_RETRY, OP_DMA: begin
            perIrq <= CNT_W'(1);
            status <= ST_XFER;
            errReg <= 8'h00;
          end
          OP_RD_MULT: begin
            perIrq <= multCount;
            status <= ST_XFER;
            errReg <= 8'h00;
          end
          OP_SET_MULT: begin
            irq <= 1'b1;
            if (tooBig) begin
              status <= ST_ABORT;
              errReg <= ER_ABORT;
            end else begin
              multCount       <= (cmdCount == 8'd0) ? CNT_W'(1) : CNT_W'(cmdCount);
              status[BIT_RDY] <= 1'b1;
              status[BIT_ERR] <= 1'b0;
              errReg          <= 8'h00;
            end
          end
          OP_ID_DISK, OP_ID_PKT: begin
            irq <= 1'b1;
            if (isPacketDrive == (cmdOp == OP_ID_PKT)) begin
              status <= ST_XFER;
              errReg <= 8'h00;
            end else begin
              status <= ST_ABORT;
              errReg <= ER_ABORT;
            end
          end
          OP_INIT_PARAM, OP_RECAL: begin
            irq              <= 1'b1;
            status[BIT_ERR]  <= 1'b0;
            status[BIT_RDY]  <= 1'b1;
            status[BIT_SEEK] <= 1'b1;
            errReg           <= 8'h00;
          end
          default: ;
        endcase
      end else if (evt.overrun) begin
        status[BIT_ERR] <= 1'b1;
        errReg          <= ER_ABORT;
      end else if (evt.irqPoint) begin
        irq             <= 1'b1;
        status[BIT_BSY] <= 1'b0;
        status[BIT_RDY] <= 1'b1;
        status[BIT_DRQ] <= ~evt.finalPoint;
      end
    end
  end

  AST_OVERRUN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    evt.overrun |=> !irq && status[BIT_ERR] && (errReg == ER_ABORT)) else $error("overrun"); // R7
  AST_FINAL_DRQ: assert property (@(posedge clk) disable iff (!rstN)
    evt.finalPoint |=> irq && !status[BIT_DRQ] && status[BIT_RDY] && !status[BIT_BSY]) else $error("final"); // R9
  AST_SETMULT_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdOp == OP_SET_MULT) && (cmdCount > MAX8)) |=>
      (status == ST_ABORT) && (errReg == ER_ABORT) && irq) else $error("set multiple abort"); // R4
  AST_MULT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (multCount != '0) && (int'(multCount) <= MAX_MULT)) else $error("block size range"); // R4
endmodule

// File: rtl/pio_irq_pacer.sv
module pio_irq_pacer
  import pacer_pkg::*;
#(
  parameter int LBA_W    = 28,
  parameter int MAX_MULT = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [7:0]       cmdOp,
  input  logic [7:0]       cmdCount,
  input  logic [LBA_W-1:0] cmdLba,
  input  logic             isPacketDrive,
  input  logic             rdValid,
  input  logic [2:0]       rdBytes,
  output logic [7:0]       status,
  output logic [7:0]       errReg,
  output logic             irq,
  output logic             nextSecReq,
  output logic [LBA_W-1:0] lba
);
  localparam int CNT_W = $clog2(MAX_MULT + 1);

  ctrl_strobe_t     strobe;
  dp_event_t        evt;
  logic [CNT_W-1:0] perIrq;

  pacer_control #(.MAX_MULT(MAX_MULT), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdCount(cmdCount), .isPacketDrive(isPacketDrive), .rdValid(rdValid),
    .evt(evt), .strobe(strobe), .perIrq(perIrq), .status(status),
    .errReg(errReg), .irq(irq)
  );

  pacer_datapath #(.LBA_W(LBA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdCount(cmdCount),
    .cmdLba(cmdLba), .rdBytes(rdBytes), .perIrq(perIrq), .evt(evt),
    .lba(lba), .nextSecReq(nextSecReq)
  );
endmodule

// File: tb/pio_irq_pacer_test.sv
`timescale 1ns/1ps
module pio_irq_pacer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdOp = 8'h00;
  logic [7:0]  cmdCount = 8'h00;
  logic [27:0] cmdLba = '0;
  logic        isPacketDrive = 1'b0;
  logic        rdValid = 1'b0;
  logic [2:0]  rdBytes = 3'd4;
  logic [7:0]  status, errReg;
  logic        irq, nextSecReq;
  logic [27:0] lba;
  int          nChecks = 0;
  int          nFails = 0;

  always #10 clk = ~clk;

  pio_irq_pacer uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdCount(cmdCount), .cmdLba(cmdLba), .isPacketDrive(isPacketDrive),
    .rdValid(rdValid), .rdBytes(rdBytes), .status(status), .errReg(errReg),
    .irq(irq), .nextSecReq(nextSecReq), .lba(lba)
  );

  // {opcode, count, packet, expected status, expected error, expected irq}
  localparam logic [47:0] VEC [10] = '{
    {8'hEC, 8'd0,  8'd0, 8'h58, 8'h00, 8'd1},  // R5 disk identify
    {8'hEC, 8'd0,  8'd1, 8'h41, 8'h04, 8'd1},  // R5 wrong type
    {8'h10, 8'd0,  8'd0, 8'h50, 8'h00, 8'd1},  // R6 recalibrate
    {8'hA1, 8'd0,  8'd0, 8'h41, 8'h04, 8'd1},  // R5 wrong type
    {8'hA1, 8'd0,  8'd1, 8'h58, 8'h00, 8'd1},  // R5 packet identify
    {8'hC6, 8'd17, 8'd0, 8'h41, 8'h04, 8'd1},  // R4 too big
    {8'h91, 8'd0,  8'd0, 8'h50, 8'h00, 8'd1},  // R6 init params
    {8'h55, 8'd0,  8'd0, 8'h50, 8'h00, 8'd0},  // R10 ignored
    {8'hC6, 8'd0,  8'd0, 8'h50, 8'h00, 8'd1},  // R4 zero count
    {8'hC6, 8'd16, 8'd0, 8'h50, 8'h00, 8'd1}   // R4 at maximum
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [7:0] cnt, input logic [27:0] addr, input logic pkt);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdCount = cnt; cmdLba = addr; isPacketDrive = pkt;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic readOnce(input logic [2:0] w);
    @(negedge clk);
    rdValid = 1'b1; rdBytes = w;
    @(negedge clk);
    rdValid = 1'b0;
  endtask

  task automatic overrunCheck(input logic [7:0] stBefore, input string req);
    readOnce(3'd4);
    check({irq, status, errReg} == {1'b0, stBefore | 8'h01, 8'h04}, req,
          {irq, status, errReg}, {1'b0, stBefore | 8'h01, 8'h04});
  endtask

  // run a whole transfer, comparing every read
  task automatic runXfer(input logic [7:0] op, input logic [7:0] cnt, input logic [27:0] start,
                         input int w, input int p, input string req);
    int len;
    int n;
    len = ((cnt == 0) ? 256 : int'(cnt)) * 512;
    n = len / w;
    issue(op, cnt, start, 1'b0);
    check({status, errReg, irq, nextSecReq, lba} == {8'h58, 8'h00, 1'b0, 1'b1, start}, req,
          {status, errReg, irq, nextSecReq, lba}, {8'h58, 8'h00, 1'b0, 1'b1, start});
    for (int k = 1; k <= n; k++) begin
      int bStart;
      int b;
      logic expIrq, expFetch;
      logic [7:0] expSt;
      logic [27:0] expLba;
      bStart = (k - 1) * w;
      b = k * w;
      expFetch = (bStart % 512 == 0) && (bStart != 0);
      expLba = start + 28'(bStart / 512);
      expIrq = (b % (512 * p) == 0) || (b == len);
      expSt = (expIrq && b == len) ? 8'h50 : 8'h58;
      readOnce(3'(w));
      check({irq, nextSecReq, status, lba} == {expIrq, expFetch, expSt, expLba},
            expIrq ? "R9 pacing" : (expFetch ? "R8 fetch" : "R7 advance"),
            {irq, nextSecReq, status, lba}, {expIrq, expFetch, expSt, expLba});
    end
    overrunCheck(8'h50, "R7 overrun at end");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset values
    check({status, errReg, irq, nextSecReq, lba} == {8'h50, 8'h00, 1'b0, 1'b0, 28'd0}, "R1 reset",
          {status, errReg, irq, nextSecReq, lba}, {8'h50, 8'h00, 1'b0, 1'b0, 28'd0});
    overrunCheck(8'h50, "R1 R7 read after reset");

    // command table
    for (int i = 0; i < 10; i++) begin
      logic [47:0] v;
      v = VEC[i];
      issue(v[47:40], v[39:32], 28'd0, v[24]);
      check({status, errReg, irq} == {v[23:16], v[15:8], v[0]}, "R4 R5 R6 R10 command table",
            {status, errReg, irq}, {v[23:16], v[15:8], v[0]});
    end

    // R2 single-sector pacing, several widths and opcodes
    runXfer(8'h20, 8'd2, 28'd100, 2, 1, "R2 read 0x20");
    runXfer(8'h24, 8'd1, 28'd7, 1, 1, "R2 read 0x24 byte wide");
    runXfer(8'hC9, 8'd3, 28'd50, 4, 1, "R2 read 0xC9");

    // R3 block mode: block of 3, seven sectors
    issue(8'hC6, 8'd3, 28'd0, 1'b0);
    check(irq && status == 8'h50, "R4 set multiple 3", {irq, status}, {1'b1, 8'h50});
    runXfer(8'hC4, 8'd7, 28'd1000, 4, 3, "R3 block of 3");

    // R4 zero count gives block size 1
    issue(8'hC6, 8'd0, 28'd0, 1'b0);
    runXfer(8'hC4, 8'd2, 28'd20, 4, 1, "R3 R4 block of 1");

    // R2 count of zero means 256 sectors
    runXfer(8'h21, 8'd0, 28'd5000, 4, 1, "R2 count zero");

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule